// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the host side of a byte-wide parallel flash bus. It turns a high-level request into the exact series of bus cycles the flash expects. A request is one of: program one byte, erase the whole chip, open a sector-erase batch with its first sector, add another sector to an open batch, or wait for an erase already under way to finish. The sequencer generates the unlock writes and the command write. For erase batches it watches the collection-window flag. It then runs the toggle-bit completion algorithm and reports the outcome through a result code.

Each bus cycle has three parts: a setup phase in which the address and write data are already driven, a strobe pulse, and a hold phase. All three lengths are parameters counted in clock cycles. When a failure or a poll timeout ends an operation, the sequencer writes the reset command before it reports back. That write returns the flash to array-read mode. While a request is running, further start pulses are ignored.

Top module: `flash_op_sequencer`

## Requirements
- R1: Request code 0 (byte program) issues exactly four writes in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, then the request data at the request address. Completion polling follows.
- R2: Request code 1 (chip erase) issues six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. Completion polling follows.
- R3: Request code 2 (open sector erase) issues the same first five writes as R2 and then 30h at the request address. It finishes with result 0 (ok) and performs no read.
- R4: Request code 3 (add sector) first reads status at the request address. If bit 3 is 1, no write is made and the result is 3 (window closed).
- R5: For request code 3 with bit 3 clear before the command, the sequencer writes 30h at the request address and reads status again. Bit 3 set on that second read gives result 4 (sector flagged); clear gives result 0.
- R6: Polling reads status twice. If bit 6 is equal in both reads, the operation ends with result 0. Request code 4 runs polling alone.
- R7: If bit 6 differs and bit 5 of the second read is 0, polling starts again with two fresh reads.
- R8: If bit 6 differs and bit 5 is 1, two more reads are made. If bit 6 still differs, the result is 1 (failed) and F0h is written at 555h before completion. If it matches, the result is 0.
- R9: After POLL_LIMIT toggling rounds with bit 5 clear, the result is 2 (timeout) and the F0h reset write is made.
- R10: Strobes stay low while not busy. A start pulse while busy has no effect on the running operation.
- R11: During a write cycle the address and data stay stable, and the write strobe is high for exactly WR_PULSE cycles. Read and write strobes are never high together.
- R12: Request codes 5 to 7 complete at once with result 5 (bad command) and make no bus cycle.
- R13: Completion is a single-cycle done pulse. The error output is high only with done, and only when the result is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start pulse for a request |
| req_cmd | input | 3 | Request code (0 program, 1 chip erase, 2 open sector erase, 3 add sector, 4 poll) |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_busy | output | 1 | Request in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Completion with a non-zero result |
| req_code | output | 3 | Result code of the last request |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data (status during operations) |
| bus_wr | output | 1 | Write strobe, active high |
| bus_rd | output | 1 | Read strobe, active high |

## Verification
A wrong sequencer state shows up on the bus before it reaches the result code. A skipped or repeated step changes the count or the content of the logged writes during the command phase. A misread status bit changes how many reads follow, within one poll round. Because the bench sets each status byte per read, a decision error in the toggle or window logic gives a wrong read count and a wrong result code on the same request. A phase-counter error in the cycle timer shows up as a wrong strobe width on the first bus cycle.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    // request codes
    localparam logic [2:0] CMD_PROG  = 3'd0;
    localparam logic [2:0] CMD_CHIP  = 3'd1;
    localparam logic [2:0] CMD_SOPEN = 3'd2;
    localparam logic [2:0] CMD_SADD  = 3'd3;
    localparam logic [2:0] CMD_POLL  = 3'd4;

    // result codes
    localparam logic [2:0] RC_OK      = 3'd0;
    localparam logic [2:0] RC_FAIL    = 3'd1;
    localparam logic [2:0] RC_TIMEOUT = 3'd2;
    localparam logic [2:0] RC_CLOSED  = 3'd3;
    localparam logic [2:0] RC_REJECT  = 3'd4;
    localparam logic [2:0] RC_BADCMD  = 3'd5;

    // status bit positions
    localparam int ST_TOGGLE = 6;
    localparam int ST_LIMIT  = 5;
    localparam int ST_WINDOW = 3;

    typedef enum logic [2:0] {
        ROP_PROG, ROP_CHIP, ROP_SECT, ROP_ADD, ROP_RST
    } rom_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMDW, S_PRE, S_POST, S_P1, S_P2, S_P3, S_P4
    } seq_st_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD
    } bus_ph_e;

endpackage

// File: rtl/fseq_bus_timer.sv
module fseq_bus_timer
    import flash_seq_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic is_read,
    output logic wr_stb,
    output logic rd_stb,
    output logic sample,
    output logic fin
);

    localparam int MAXC = (SETUP_CYC > PULSE_CYC) ?
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                          ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
    localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CW-1:0] SET_END = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PUL_END = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HLD_END = CW'(HOLD_CYC - 1);

    typedef struct packed {
        bus_ph_e       ph;
        logic [CW-1:0] cnt;
        logic          rd;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        sample = 1'b0;
        fin    = 1'b0;
        unique case (t_q.ph)
            PH_IDLE: begin
                if (launch) begin
                    t_d.ph  = PH_SETUP;
                    t_d.cnt = '0;
                    t_d.rd  = is_read;
                end
            end
            PH_SETUP: begin
                if (t_q.cnt == SET_END) begin
                    t_d.ph  = PH_PULSE;
                    t_d.cnt = '0;
                end else begin
                    t_d.cnt = t_q.cnt + 1'b1;
                end
            end
            PH_PULSE: begin
                if (t_q.cnt == PUL_END) begin
                    sample  = t_q.rd;
                    t_d.ph  = PH_HOLD;
                    t_d.cnt = '0;
                end else begin
                    t_d.cnt = t_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (t_q.cnt == HLD_END) begin
                    fin     = 1'b1;
                    t_d.ph  = PH_IDLE;
                    t_d.cnt = '0;
                end else begin
                    t_d.cnt = t_q.cnt + 1'b1;
                end
            end
            default: t_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{ph: PH_IDLE, cnt: '0, rd: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign wr_stb = (t_q.ph == PH_PULSE) && !t_q.rd;
    assign rd_stb = (t_q.ph == PH_PULSE) &&  t_q.rd;

endmodule

// File: rtl/fseq_cmd_rom.sv
module fseq_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int AW = 17
) (
    input  rom_op_e         op,
    input  logic [2:0]      step,
    input  logic [AW-1:0]   tgt,
    input  logic [7:0]      pdata,
    output logic [AW-1:0]   addr,
    output logic [7:0]      data,
    output logic            last
);

    localparam logic [AW-1:0] A_ODD  = AW'(12'h555);
    localparam logic [AW-1:0] A_EVEN = AW'(12'h2AA);

    // shared unlock pair: even steps AAh@555h, odd steps 55h@2AAh
    logic [AW-1:0] ul_addr;
    logic [7:0]    ul_data;

    always_comb begin
        ul_addr = step[0] ? A_EVEN : A_ODD;
        ul_data = step[0] ? 8'h55  : 8'hAA;
    end

    always_comb begin
        addr = A_ODD;
        data = 8'h00;
        last = 1'b0;
        unique case (op)
            ROP_PROG: begin
                if (step < 3'd2) begin
                    addr = ul_addr;
                    data = ul_data;
                end else if (step == 3'd2) begin
                    addr = A_ODD;
                    data = 8'hA0;
                end else begin
                    addr = tgt;
                    data = pdata;
                    last = 1'b1;
                end
            end
            ROP_CHIP, ROP_SECT: begin
                if (step == 3'd2) begin
                    addr = A_ODD;
                    data = 8'h80;
                end else if (step < 3'd2) begin
                    addr = ul_addr;
                    data = ul_data;
                end else if (step < 3'd5) begin
                    addr = step[0] ? A_ODD : A_EVEN;
                    data = step[0] ? 8'hAA : 8'h55;
                end else begin
                    addr = (op == ROP_CHIP) ? A_ODD : tgt;
                    data = (op == ROP_CHIP) ? 8'h10 : 8'h30;
                    last = 1'b1;
                end
            end
            ROP_ADD: begin
                addr = tgt;
                data = 8'h30;
                last = 1'b1;
            end
            default: begin
                addr = A_ODD;
                data = 8'hF0;
                last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
    import flash_seq_pkg::*;
#(
    parameter int AW         = 17,
    parameter int SETUP_CYC  = 1,
    parameter int WR_PULSE   = 2,
    parameter int HOLD_CYC   = 1,
    parameter int POLL_LIMIT = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic [2:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          req_busy,
    output logic          req_done,
    output logic          req_err,
    output logic [2:0]    req_code,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata,
    output logic          bus_wr,
    output logic          bus_rd
);

    localparam int PCW = $clog2(POLL_LIMIT + 1);
    localparam logic [PCW-1:0] P_LAST = PCW'(POLL_LIMIT - 1);

    typedef struct packed {
        seq_st_e        st;
        rom_op_e        op;
        logic [2:0]     step;
        logic [AW-1:0]  tgt;
        logic [7:0]     wdat;
        logic [7:0]     rcap;
        logic [7:0]     rfirst;
        logic [PCW-1:0] pcnt;
        logic [2:0]     code;
        logic           launch;
        logic           done;
    } seq_t;

    seq_t s_d, s_q;

    logic          t_sample, t_fin, t_wr, t_rd;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          rom_last;
    logic          toggled;

    fseq_bus_timer #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(WR_PULSE),
        .HOLD_CYC (HOLD_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (s_q.launch),
        .is_read(s_q.st != S_CMDW),
        .wr_stb (t_wr),
        .rd_stb (t_rd),
        .sample (t_sample),
        .fin    (t_fin)
    );

    fseq_cmd_rom #(.AW(AW)) u_rom (
        .op   (s_q.op),
        .step (s_q.step),
        .tgt  (s_q.tgt),
        .pdata(s_q.wdat),
        .addr (rom_addr),
        .data (rom_data),
        .last (rom_last)
    );

    assign toggled = s_q.rfirst[ST_TOGGLE] ^ s_q.rcap[ST_TOGGLE];

    always_comb begin
        s_d        = s_q;
        s_d.launch = 1'b0;
        s_d.done   = 1'b0;
        if (t_sample) s_d.rcap = bus_rdata;
        unique case (s_q.st)
            S_IDLE: begin
                if (req_start) begin
                    s_d.tgt  = req_addr;
                    s_d.wdat = req_data;
                    s_d.step = '0;
                    s_d.pcnt = '0;
                    s_d.code = RC_OK;
                    s_d.launch = 1'b1;
                    unique case (req_cmd)
                        CMD_PROG:  begin s_d.op = ROP_PROG; s_d.st = S_CMDW; end
                        CMD_CHIP:  begin s_d.op = ROP_CHIP; s_d.st = S_CMDW; end
                        CMD_SOPEN: begin s_d.op = ROP_SECT; s_d.st = S_CMDW; end
                        CMD_SADD:  s_d.st = S_PRE;
                        CMD_POLL:  s_d.st = S_P1;
                        default: begin
                            s_d.launch = 1'b0;
                            s_d.done   = 1'b1;
                            s_d.code   = RC_BADCMD;
                        end
                    endcase
                end
            end
            S_CMDW: begin
                if (t_fin) begin
                    if (!rom_last) begin
                        s_d.step   = s_q.step + 1'b1;
                        s_d.launch = 1'b1;
                    end else begin
                        unique case (s_q.op)
                            ROP_PROG, ROP_CHIP: begin
                                s_d.st = S_P1; s_d.pcnt = '0; s_d.launch = 1'b1;
                            end
                            ROP_SECT: begin
                                s_d.st = S_IDLE; s_d.done = 1'b1; s_d.code = RC_OK;
                            end
                            ROP_ADD: begin
                                s_d.st = S_POST; s_d.launch = 1'b1;
                            end
                            default: begin
                                s_d.st = S_IDLE; s_d.done = 1'b1;
                            end
                        endcase
                    end
                end
            end
            S_PRE: begin
                if (t_fin) begin
                    if (s_q.rcap[ST_WINDOW]) begin
                        s_d.st = S_IDLE; s_d.done = 1'b1; s_d.code = RC_CLOSED;
                    end else begin
                        s_d.op = ROP_ADD; s_d.step = '0;
                        s_d.st = S_CMDW; s_d.launch = 1'b1;
                    end
                end
            end
            S_POST: begin
                if (t_fin) begin
                    s_d.st   = S_IDLE;
                    s_d.done = 1'b1;
                    s_d.code = s_q.rcap[ST_WINDOW] ? RC_REJECT : RC_OK;
                end
            end
            S_P1, S_P3: begin
                if (t_fin) begin
                    s_d.rfirst = s_q.rcap;
                    s_d.st     = (s_q.st == S_P1) ? S_P2 : S_P4;
                    s_d.launch = 1'b1;
                end
            end
            S_P2: begin
                if (t_fin) begin
                    if (!toggled) begin
                        s_d.st = S_IDLE; s_d.done = 1'b1; s_d.code = RC_OK;
                    end else if (s_q.rcap[ST_LIMIT]) begin
                        s_d.st = S_P3; s_d.launch = 1'b1;
                    end else if (s_q.pcnt == P_LAST) begin
                        s_d.code = RC_TIMEOUT; s_d.op = ROP_RST; s_d.step = '0;
                        s_d.st = S_CMDW; s_d.launch = 1'b1;
                    end else begin
                        s_d.pcnt = s_q.pcnt + 1'b1;
                        s_d.st = S_P1; s_d.launch = 1'b1;
                    end
                end
            end
            S_P4: begin
                if (t_fin) begin
                    if (!toggled) begin
                        s_d.st = S_IDLE; s_d.done = 1'b1; s_d.code = RC_OK;
                    end else begin
                        s_d.code = RC_FAIL; s_d.op = ROP_RST; s_d.step = '0;
                        s_d.st = S_CMDW; s_d.launch = 1'b1;
                    end
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: S_IDLE, op: ROP_RST, step: '0, tgt: '0, wdat: '0,
                     rcap: '0, rfirst: '0, pcnt: '0, code: RC_OK,
                     launch: 1'b0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_busy  = (s_q.st != S_IDLE);
    assign req_done  = s_q.done;
    assign req_err   = s_q.done && (s_q.code != RC_OK);
    assign req_code  = s_q.code;
    assign bus_addr  = (s_q.st == S_CMDW) ? rom_addr : s_q.tgt;
    assign bus_wdata = (s_q.st == S_CMDW) ? rom_data : 8'h00;
    assign bus_wr    = t_wr;
    assign bus_rd    = t_rd;

endmodule

// File: rtl/flash_op_sequencer_chk.sv
module flash_op_sequencer_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_busy,
    input logic          req_done,
    input logic          req_err,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata
);

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    p_wr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && $past(bus_wr)) |-> ($stable(bus_addr) && $stable(bus_wdata)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> (!bus_wr && !bus_rd));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    p_err_with_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_done);

    p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> !req_busy);

endmodule

bind flash_op_sequencer flash_op_sequencer_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_busy (req_busy),
    .req_done (req_done),
    .req_err  (req_err),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata)
);

// File: tb/flash_op_sequencer_tb.sv
module flash_op_sequencer_tb;

    localparam int AW = 17;
    localparam int WRP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [2:0]    req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          req_busy, req_done, req_err;
    logic [2:0]    req_code;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;
    logic          bus_wr, bus_rd;

    always #4 clk = ~clk;   // 125 MHz

    flash_op_sequencer #(
        .AW(AW), .SETUP_CYC(2), .WR_PULSE(WRP), .HOLD_CYC(1), .POLL_LIMIT(3)
    ) u_dut (.*);

    // bus responder: status byte per read from a script
    logic [63:0]   scr = '0;
    logic          tog_mode = 1'b0;
    int            nrd = 0;
    int            nwr = 0;
    logic [AW-1:0] wa [16];
    logic [7:0]    wd [16];
    int            wcnt = 0;
    int            last_w = 0;

    always_comb begin
        if (tog_mode) bus_rdata = {1'b0, nrd[0], 6'b0};
        else          bus_rdata = scr[((nrd > 7) ? 7 : nrd) * 8 +: 8];
    end

    always @(negedge bus_rd) nrd = nrd + 1;
    always @(posedge bus_wr) begin
        if (nwr < 16) begin
            wa[nwr] = bus_addr;
            wd[nwr] = bus_wdata;
        end
        nwr = nwr + 1;
    end
    always @(negedge clk) begin
        if (bus_wr) wcnt = wcnt + 1;
        else if (wcnt != 0) begin
            last_w = wcnt;
            wcnt = 0;
        end
    end

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]    cmd;
        logic [16:0]   addr;
        logic [7:0]    data;
        logic [63:0]   scr;
        logic [2:0]    code;
        logic [4:0]    nwr;
        logic [4:0]    nrd;
        logic [16:0]   la;
        logic [7:0]    ld;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        // R1/R6: program, status stable at once
        '{3'd0, 17'h01234, 8'h5A, 64'h4040, 3'd0, 5'd4, 5'd2, 17'h01234, 8'h5A, 4'd1},
        // R2/R7: chip erase, toggle with bit5 clear then stable
        '{3'd1, 17'h00000, 8'h00, 64'h4000, 3'd0, 5'd6, 5'd4, 17'h00555, 8'h10, 4'd2},
        // R3: open sector erase, no reads
        '{3'd2, 17'h08000, 8'h00, 64'h0,    3'd0, 5'd6, 5'd0, 17'h08000, 8'h30, 4'd3},
        // R5: add sector accepted
        '{3'd3, 17'h0C000, 8'h00, 64'h0,    3'd0, 5'd1, 5'd2, 17'h0C000, 8'h30, 4'd5},
        // R4: window already closed
        '{3'd3, 17'h10000, 8'h00, 64'h08,   3'd3, 5'd0, 5'd1, 17'h00000, 8'h00, 4'd4},
        // R5: sector flagged after command
        '{3'd3, 17'h14000, 8'h00, 64'h0800, 3'd4, 5'd1, 5'd2, 17'h14000, 8'h30, 4'd5},
        // R8: toggle with bit5 set, then stops -> ok
        '{3'd4, 17'h14000, 8'h00, 64'h40406000, 3'd0, 5'd0, 5'd4, 17'h00000, 8'h00, 4'd8},
        // R8: still toggling -> fail and reset write
        '{3'd4, 17'h14000, 8'h00, 64'h40006000, 3'd1, 5'd1, 5'd4, 17'h00555, 8'hF0, 4'd8},
        // R12: undefined request code
        '{3'd6, 17'h00000, 8'h00, 64'h0,    3'd5, 5'd0, 5'd0, 17'h00000, 8'h00, 4'd12}
    };

    bit hung = 1'b0;
    logic [2:0] got_code;
    logic       got_err;

    task automatic launch_req(input logic [2:0] c, input logic [16:0] a, input logic [7:0] d);
        nrd = 0;
        nwr = 0;
        @(negedge clk);
        req_cmd = c; req_addr = a; req_data = d; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic wait_done();
        bit seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (req_done) begin
                seen = 1'b1;
                got_code = req_code;
                got_err = req_err;
            end else begin
                @(negedge clk);
            end
        end
        if (!seen) begin
            hung = 1'b1;
            chk(1'b0, "watchdog", "request never completed", 0, 1);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R10/R13
        chk(!req_busy && !req_done && !req_err, "R13", "reset outputs", req_busy, 0);
        chk(!bus_wr && !bus_rd, "R10", "strobes in reset", bus_wr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            scr = VEC[v].scr;
            tog_mode = 1'b0;
            launch_req(VEC[v].cmd, VEC[v].addr, VEC[v].data);
            wait_done();
            chk(got_code == VEC[v].code, $sformatf("R%0d", VEC[v].req), "result code",
                got_code, VEC[v].code);
            chk(got_err == (VEC[v].code != 3'd0), "R13", "error flag", got_err,
                VEC[v].code != 3'd0);
            chk(nwr == int'(VEC[v].nwr), $sformatf("R%0d", VEC[v].req), "write count",
                nwr, VEC[v].nwr);
            chk(nrd == int'(VEC[v].nrd), $sformatf("R%0d", VEC[v].req), "read count",
                nrd, VEC[v].nrd);
            if (VEC[v].nwr != 0 && nwr > 0 && nwr <= 16) begin
                chk(wa[nwr-1] == VEC[v].la, $sformatf("R%0d", VEC[v].req), "last write addr",
                    wa[nwr-1], VEC[v].la);
                chk(wd[nwr-1] == VEC[v].ld, $sformatf("R%0d", VEC[v].req), "last write data",
                    wd[nwr-1], VEC[v].ld);
            end
            if (v == 0 && nwr == 4) begin
                // R1 unlock order
                chk(wa[0] == 17'h555 && wd[0] == 8'hAA, "R1", "write 1", wd[0], 8'hAA);
                chk(wa[1] == 17'h2AA && wd[1] == 8'h55, "R1", "write 2", wd[1], 8'h55);
                chk(wa[2] == 17'h555 && wd[2] == 8'hA0, "R1", "write 3", wd[2], 8'hA0);
                // R11 strobe width
                chk(last_w == WRP, "R11", "write pulse width", last_w, WRP);
            end
            if (v == 1 && nwr == 6) begin
                chk(wa[2] == 17'h555 && wd[2] == 8'h80, "R2", "setup write", wd[2], 8'h80);
                chk(wa[4] == 17'h2AA && wd[4] == 8'h55, "R2", "second unlock", wd[4], 8'h55);
            end
            if (v == 2 && nwr == 6) begin
                chk(wa[3] == 17'h555 && wd[3] == 8'hAA, "R3", "fourth write", wd[3], 8'hAA);
            end
            chk(!bus_wr && !bus_rd, "R10", "strobes idle after done", bus_wr, 0);
        end

        // R9: endless toggling with bit5 clear -> timeout after 3 rounds
        tog_mode = 1'b1;
        launch_req(3'd4, 17'h00010, 8'h00);
        wait_done();
        chk(got_code == 3'd2, "R9", "timeout code", got_code, 2);
        chk(nrd == 6, "R9", "reads before timeout", nrd, 6);
        chk(nwr == 1 && wd[0] == 8'hF0, "R9", "reset write", wd[0], 8'hF0);
        tog_mode = 1'b0;

        // R10: start while busy is ignored
        scr = 64'h4040;
        launch_req(3'd0, 17'h00100, 8'h33);
        repeat (5) @(negedge clk);
        chk(req_busy, "R10", "busy during program", req_busy, 1);
        req_cmd = 3'd1; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done();
        chk(got_code == 3'd0, "R10", "code after ignored start", got_code, 0);
        chk(nwr == 4, "R10", "writes after ignored start", nwr, 4);
        if (nwr == 4)
            chk(wa[3] == 17'h00100 && wd[3] == 8'h33, "R10", "program target", wd[3], 8'h33);
        repeat (3) @(negedge clk);
        chk(!req_busy && !bus_wr && !bus_rd, "R10", "quiet after finish", req_busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule